// File: doc/BRIEF.md
# Pulse-Width Infrared Frame Transmitter

This block sends one infrared remote-control frame per request. Each data bit is carried by how long the output stays high (the mark). A 1 gives a long mark and a 0 gives a short mark. Every mark is followed by a low gap (the space) of fixed length. A frame opens with a longer start mark. It then sends a 7-bit command and a 5-bit address, and ends with low padding. The padding makes every frame last the same fixed period, whatever its data.

Software places the command and address on the inputs and pulses `start` for one clock. The values are captured on that clock. All timing is counted in units. The length of one unit in clocks is set by a parameter that divides down the system clock.

If a request arrives while a frame is still in progress, it is held. The held request is launched on the clock where the current period ends. A later request made while one is already held replaces the held data.

Top module: `sirc_tx`

## Requirements
- R1: After reset `ir_out`, `busy` and `done` are all low.
- R2: A launch raises `ir_out` on the next clock. The start mark lasts START_UNITS units and is followed by SPACE_UNITS units of low output.
- R3: Data bits follow the start space in this order: command bit 0 up to command bit 6, then address bit 0 up to address bit 4.
- R4: A data bit of 1 is a mark of ONE_UNITS units and a data bit of 0 is a mark of ZERO_UNITS units. Every data mark is followed by SPACE_UNITS units low.
- R5: `busy` is high for exactly FRAME_UNITS units from the clock after a launch. `ir_out` stays low from the end of the last space until the period ends, and it is never high while `busy` is low.
- R6: `done` is high for exactly one clock, the first clock after a period ends.
- R7: A `start` pulse while `busy` is high is held pending. It is launched at the end of the period, so the next frame follows with no idle clock. If several pulses arrive, the data of the latest one is sent.
- R8: A `start` pulse while idle launches a frame on the next clock, using the `cmd` and `addr` values present with the pulse.
- R9: One unit lasts exactly CLK_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-clock request to send a frame |
| cmd | input | CMD_W | Command field, captured with `start` |
| addr | input | ADDR_W | Address field, captured with `start` |
| ir_out | output | 1 | Unmodulated frame output, high during marks |
| busy | output | 1 | High while a frame period is running |
| done | output | 1 | One-clock pulse after each period ends |

## Verification
The bench builds the block with CLK_DIV set to 3 and keeps the default unit counts and the 75-unit period. One frame then lasts 225 clocks. This lets all-zero data, all-one data, mixed data, pending requests and back-to-back frames all run in a short test. A divider of 3 still keeps every unit more than one clock long, so an off-by-one in the divider shows up as a shifted edge.

// File: rtl/sirc_pkg.sv
package sirc_pkg;
  typedef enum logic [1:0] {PH_MARK, PH_SPACE, PH_PAD} phase_e;

  // length in units of the mark that encodes one data bit
  function automatic int unsigned mark_len(input logic b, input int unsigned one_u,
                                           input int unsigned zero_u);
    return b ? one_u : zero_u;
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/sirc_unit_tick.sv
module sirc_unit_tick #(
  parameter int unsigned CLK_DIV = 60000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int unsigned CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == CW'(CLK_DIV - 1));
  assign tick = run && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || restart)  cnt <= '0;
    else if (wrap)             cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sirc_period.sv
module sirc_period #(
  parameter int unsigned FRAME_UNITS = 75
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  output logic frame_end
);
  localparam int unsigned FW = $clog2(FRAME_UNITS + 1);
  logic [FW-1:0] ucnt;
  logic          last_unit;

  assign last_unit = (ucnt == FW'(FRAME_UNITS - 1));
  assign frame_end = tick && last_unit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ucnt <= '0;
    else if (restart)            ucnt <= '0;
    else if (tick && last_unit)  ucnt <= '0;
    else if (tick)               ucnt <= ucnt + 1'b1;
  end
endmodule

// File: rtl/sirc_shaper.sv
module sirc_shaper
  import sirc_pkg::*;
#(
  parameter int unsigned NBITS       = 12,
  parameter int unsigned START_UNITS = 4,
  parameter int unsigned ONE_UNITS   = 2,
  parameter int unsigned ZERO_UNITS  = 1,
  parameter int unsigned SPACE_UNITS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NBITS-1:0] data,
  input  logic             tick,
  output logic             ir_out,
  output logic             pad
);
  localparam int unsigned MAXU = max4(START_UNITS, ONE_UNITS, ZERO_UNITS, SPACE_UNITS);
  localparam int unsigned SW   = $clog2(MAXU + 1);
  localparam int unsigned IW   = $clog2(NBITS + 1);

  phase_e           phase;
  logic [SW-1:0]    seg_left;
  logic [IW-1:0]    idx;
  logic [NBITS-1:0] shreg;
  logic             seg_done;

  assign seg_done = tick && (seg_left == '0);
  assign ir_out   = (phase == PH_MARK);
  assign pad      = (phase == PH_PAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_PAD;
      seg_left <= '0;
      idx      <= '0;
      shreg    <= '0;
    end else if (load) begin
      phase    <= PH_MARK;
      seg_left <= SW'(START_UNITS - 1);
      idx      <= '0;
      shreg    <= data;
    end else if (tick && !seg_done) begin
      seg_left <= seg_left - 1'b1;
    end else if (seg_done) begin
      unique case (phase)
        PH_MARK: begin
          phase    <= PH_SPACE;
          seg_left <= SW'(SPACE_UNITS - 1);
        end
        PH_SPACE: begin
          if (idx == IW'(NBITS)) begin
            phase <= PH_PAD;
          end else begin
            phase    <= PH_MARK;
            seg_left <= SW'(mark_len(shreg[0], ONE_UNITS, ZERO_UNITS) - 1);
            shreg    <= shreg >> 1;
            idx      <= idx + 1'b1;
          end
        end
        default: phase <= PH_PAD;
      endcase
    end
  end

  // R2
  launch_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ir_out);
endmodule

// File: rtl/sirc_tx.sv
module sirc_tx #(
  parameter int unsigned CLK_DIV     = 60000,
  parameter int unsigned CMD_W       = 7,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned START_UNITS = 4,
  parameter int unsigned ONE_UNITS   = 2,
  parameter int unsigned ZERO_UNITS  = 1,
  parameter int unsigned SPACE_UNITS = 1,
  parameter int unsigned FRAME_UNITS = 75
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [ADDR_W-1:0] addr,
  output logic              ir_out,
  output logic              busy,
  output logic              done
);
  localparam int unsigned NBITS = CMD_W + ADDR_W;

  logic             tick, frame_end, launch, pend, pad;
  logic [NBITS-1:0] hold, launch_data;

  assign launch      = (!busy && start) || (frame_end && (start || pend));
  assign launch_data = start ? {addr, cmd} : hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      pend <= 1'b0;
      hold <= '0;
    end else begin
      done <= frame_end;
      if (launch)         busy <= 1'b1;
      else if (frame_end) busy <= 1'b0;
      if (launch)         pend <= 1'b0;
      else if (start)     pend <= 1'b1;
      if (start)          hold <= {addr, cmd};
    end
  end

  sirc_unit_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .restart(launch), .tick(tick));

  sirc_period #(.FRAME_UNITS(FRAME_UNITS)) u_period (
    .clk(clk), .rst_n(rst_n), .restart(launch), .tick(tick), .frame_end(frame_end));

  sirc_shaper #(
    .NBITS(NBITS), .START_UNITS(START_UNITS), .ONE_UNITS(ONE_UNITS),
    .ZERO_UNITS(ZERO_UNITS), .SPACE_UNITS(SPACE_UNITS)
  ) u_shaper (
    .clk(clk), .rst_n(rst_n), .load(launch), .data(launch_data), .tick(tick),
    .ir_out(ir_out), .pad(pad));

  // R7
  pend_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> busy);
  // R5
  ir_quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ir_out);
  // R5
  bits_fit_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> pad);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/sirc_tx_tb.sv
module sirc_tx_tb;
  localparam int DIV = 3, ST = 4, ONE = 2, ZERO = 1, SP = 1, FR = 75;

  logic       clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [6:0] cmd = '0;
  logic [4:0] addr = '0;
  logic       ir_out, busy, done;
  int checks = 0, errors = 0, cycles = 0;

  always #5 clk = ~clk;

  sirc_tx #(.CLK_DIV(DIV), .START_UNITS(ST), .ONE_UNITS(ONE), .ZERO_UNITS(ZERO),
            .SPACE_UNITS(SP), .FRAME_UNITS(FR)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .addr(addr),
    .ir_out(ir_out), .busy(busy), .done(done));

  // reference model state
  bit m_active = 0, m_pend = 0, m_done = 0;
  int m_t = 0;
  logic [11:0] m_data = '0, m_hold = '0;

  function automatic bit exp_ir(input logic [11:0] d, input int t);
    int u, pos, m;
    u = t / DIV;
    if (u < ST) return 1'b1;
    pos = ST + SP;
    if (u < pos) return 1'b0;
    for (int i = 0; i < 12; i++) begin
      m = d[i] ? ONE : ZERO;
      if (u < pos + m) return 1'b1;
      pos += m + SP;
      if (u < pos) return 1'b0;
    end
    return 1'b0;
  endfunction

  function automatic string ir_tag(input int t);
    int pos;
    pos = ST + SP;
    for (int i = 0; i < 12; i++) pos += ((m_data[i] ? ONE : ZERO) + SP);
    if (t / DIV < ST + SP) return "R2 R9";
    if (t / DIV < pos)     return "R3 R4 R9";
    return "R5";
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at t=%0t: actual %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst_n) begin
      m_done = 0;
      if (m_active) begin
        m_t++;
        if (m_t == FR * DIV) begin m_done = 1; m_active = 0; end
      end
      if ((start && !m_active) || (m_done && m_pend)) begin
        m_data = start ? {addr, cmd} : m_hold;
        m_active = 1; m_t = 0; m_pend = 0;
      end else if (start) begin
        m_pend = 1; m_hold = {addr, cmd};
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(m_active ? ir_tag(m_t) : "R5", ir_out, m_active ? exp_ir(m_data, m_t) : 1'b0);
      check("R5 R7 R8", busy, m_active);
      check("R6", done, m_done);
    end
  end

  task automatic pulse(input logic [6:0] c, input logic [4:0] a);
    @(negedge clk); start = 1'b1; cmd = c; addr = a;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_active) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", ir_out, 1'b0);
    check("R1", busy, 1'b0);
    check("R1", done, 1'b0);
    rst_n = 1'b1;
    // R8 all zeros, then R4 all ones
    pulse(7'h00, 5'h00); wait_idle();
    pulse(7'h7F, 5'h1F); wait_idle();
    // R3 mixed patterns expose bit order
    pulse(7'h35, 5'h16); wait_idle();
    pulse(7'h01, 5'h10); wait_idle();
    // R7 pending requests, latest wins, back-to-back frames
    pulse(7'h2A, 5'h05);
    repeat (40) @(negedge clk);
    pulse(7'h4A, 5'h09);
    repeat (30) @(negedge clk);
    pulse(7'h2B, 5'h11);
    while (!done) @(negedge clk);
    repeat (2) @(negedge clk);
    check("R7", busy, 1'b1);
    wait_idle();
    // R7 request on the very last clock of a period
    pulse(7'h0F, 5'h03);
    while (!(m_active && m_t == FR * DIV - 2)) @(negedge clk);
    pulse(7'h70, 5'h0C);
    wait_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    while (cycles < 20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule